// File: doc/BRIEF.md
# Decode-Stage Hazard Controller

This block sits beside the decode stage of a five-stage in-order pipeline and decides, every cycle, whether the front end advances, holds or is cleared. It compares the destination register of a memory read now in execute with the two source register fields of the instruction in decode. On a match it freezes the program counter and the fetch/decode register for one cycle and tells the datapath to zero the control word entering the decode/execute register, which forms a bubble.

The same controller also turns two redirect events into per-stage flush lines. When a branch resolved in decode is taken, the pipeline has assumed it would not be, so only the instruction in fetch is discarded. When the instruction in execute overflows, fetch, decode and execute are cleared, the faulting instruction is kept from writing its result register, the PC is steered to a fixed handler address, and the address of the faulting instruction is stored with a cause code. Priority runs overflow, then branch, then stall. All hold, bubble and flush outputs are combinational on the current inputs. Only the stored address, the cause and a one-bit stall history are registered.

Top module: `hazard_ctrl`

## Requirements
- R1: When `ex_mem_rd_i` is 1 and `ex_dst_i` equals `id_src_a_i` or `id_src_b_i`, with no overflow, no branch and no stall in the previous cycle, `pc_we_o` and `ifid_we_o` are 0 and `ctrl_zero_o` is 1 in that cycle. No flush line is raised.
- R2: When `ex_mem_rd_i` is 0, or neither source field matches `ex_dst_i`, and there is no branch or overflow, `pc_we_o` and `ifid_we_o` are 1 and `ctrl_zero_o`, all flush lines, `wb_kill_o` and `redirect_o` are 0.
- R3: A stall never lasts two consecutive cycles. If the load-use condition still holds in the cycle after a stall, the pipeline runs (R2 outputs), and it may stall again in the cycle after that.
- R4: When `br_taken_i` is 1 and `ovf_i` is 0, `flush_if_o` is 1, `flush_id_o` and `flush_ex_o` are 0, `pc_we_o` and `ifid_we_o` are 1 and `ctrl_zero_o` is 0. Any simultaneous load-use stall is dropped.
- R5: When `ovf_i` is 1, `flush_if_o`, `flush_id_o`, `flush_ex_o`, `ctrl_zero_o`, `wb_kill_o` and `redirect_o` are all 1, `pc_we_o` and `ifid_we_o` are 1, and `redirect_pc_o` equals parameter `HANDLER_PC`. When `redirect_o` is 0, `redirect_pc_o` is 0.
- R6: Overflow takes precedence over both a taken branch and a load-use match in the same cycle, and the outputs are exactly those of R5.
- R7: On each clock edge where `ovf_i` is 1, `epc_o` loads `ex_pc_i` and `cause_o` loads parameter `CAUSE_OVF` (default 12). On edges where `ovf_i` is 0, both keep their value.
- R8: While `rst_ni` is 0, `epc_o` and `cause_o` are 0 and the stall history is cleared. The first load-use match after reset therefore stalls.
- R9: `wb_kill_o` and `redirect_o` are 0 in every cycle where `ovf_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ex_mem_rd_i | input | 1 | Instruction in execute reads data memory |
| ex_dst_i | input | REG_W | Destination register of the instruction in execute |
| id_src_a_i | input | REG_W | First source register field in fetch/decode register |
| id_src_b_i | input | REG_W | Second source register field in fetch/decode register |
| br_taken_i | input | 1 | Branch resolved in decode is taken |
| ovf_i | input | 1 | Arithmetic overflow in execute |
| ex_pc_i | input | ADDR_W | Address of the instruction in execute |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ctrl_zero_o | output | 1 | Zero control word into decode/execute register |
| flush_if_o | output | 1 | Discard instruction in fetch |
| flush_id_o | output | 1 | Discard instruction in decode |
| flush_ex_o | output | 1 | Discard instruction in execute |
| wb_kill_o | output | 1 | Block register write of the faulting instruction |
| redirect_o | output | 1 | Load PC from `redirect_pc_o` |
| redirect_pc_o | output | ADDR_W | Handler address while redirecting |
| epc_o | output | ADDR_W | Recorded faulting instruction address |
| cause_o | output | CAUSE_W | Recorded cause code |

## Verification
The bench builds the block with REG_W=5, ADDR_W=32, CAUSE_W=5, HANDLER_PC=0x180 and CAUSE_OVF=12. The 5-bit register field is small enough to sweep every destination index against each source port. This shows that the match logic has no index-dependent gap. The 32-bit address width lets the bench use distinct, recognisable faulting addresses, so it can confirm that the recorded address is taken from the overflow cycle itself and is held through later branches and stalls.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  typedef enum logic [1:0] {
    ACT_RUN    = 2'd0,
    ACT_STALL  = 2'd1,
    ACT_BRANCH = 2'd2,
    ACT_TRAP   = 2'd3
  } hz_act_e;

  typedef struct packed {
    logic if_f;
    logic id_f;
    logic ex_f;
  } flush_t;
endpackage

// File: rtl/hz_load_use_det.sv
`timescale 1ns/1ps
module hz_load_use_det #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                          ld_i,
  input  logic [REG_W-1:0]              dst_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  output logic                          hit_o
);
  logic [NUM_SRC-1:0] match;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign match[g] = (src_i[g] == dst_i);
  end

  assign hit_o = ld_i & (|match);
endmodule

// File: rtl/hz_arbiter.sv
`timescale 1ns/1ps
module hz_arbiter
  import hz_pkg::*;
(
  input  logic    hit_i,
  input  logic    stalled_q_i,
  input  logic    br_i,
  input  logic    ovf_i,
  output hz_act_e act_o
);
  // overflow > branch > load-use; no back-to-back stall
  always_comb begin
    if (ovf_i)                     act_o = ACT_TRAP;
    else if (br_i)                 act_o = ACT_BRANCH;
    else if (hit_i && !stalled_q_i) act_o = ACT_STALL;
    else                           act_o = ACT_RUN;
  end
endmodule

// File: rtl/hz_trap_rec.sv
`timescale 1ns/1ps
module hz_trap_rec #(
  parameter int                 ADDR_W    = 32,
  parameter int                 CAUSE_W   = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_OVF = CAUSE_W'(12)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic [ADDR_W-1:0]  epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (trap_i) begin
      epc_o   <= pc_i;
      cause_o <= CAUSE_OVF;
    end
  end

  p_epc_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (epc_o == $past(pc_i)) && (cause_o == CAUSE_OVF));
  p_epc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i |=> $stable(epc_o) && $stable(cause_o));
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int                 REG_W      = 5,
  parameter int                 ADDR_W     = 32,
  parameter int                 CAUSE_W    = 5,
  parameter logic [ADDR_W-1:0]  HANDLER_PC = ADDR_W'(32'h180),
  parameter logic [CAUSE_W-1:0] CAUSE_OVF  = CAUSE_W'(12)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ex_mem_rd_i,
  input  logic [REG_W-1:0]   ex_dst_i,
  input  logic [REG_W-1:0]   id_src_a_i,
  input  logic [REG_W-1:0]   id_src_b_i,
  input  logic               br_taken_i,
  input  logic               ovf_i,
  input  logic [ADDR_W-1:0]  ex_pc_i,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               ctrl_zero_o,
  output logic               flush_if_o,
  output logic               flush_id_o,
  output logic               flush_ex_o,
  output logic               wb_kill_o,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  redirect_pc_o,
  output logic [ADDR_W-1:0]  epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] srcs;
  logic    hit;
  logic    stalled_q;
  hz_act_e act;
  flush_t  flush;

  assign srcs = {id_src_b_i, id_src_a_i};

  hz_load_use_det #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_det (
    .ld_i  (ex_mem_rd_i),
    .dst_i (ex_dst_i),
    .src_i (srcs),
    .hit_o (hit)
  );

  hz_arbiter u_arb (
    .hit_i       (hit),
    .stalled_q_i (stalled_q),
    .br_i        (br_taken_i),
    .ovf_i       (ovf_i),
    .act_o       (act)
  );

  hz_trap_rec #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .CAUSE_OVF(CAUSE_OVF)) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trap_i  (act == ACT_TRAP),
    .pc_i    (ex_pc_i),
    .epc_o   (epc_o),
    .cause_o (cause_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stalled_q <= 1'b0;
    else         stalled_q <= (act == ACT_STALL);
  end

  always_comb begin
    pc_we_o     = 1'b1;
    ifid_we_o   = 1'b1;
    ctrl_zero_o = 1'b0;
    flush       = '0;
    wb_kill_o   = 1'b0;
    redirect_o  = 1'b0;
    unique case (act)
      ACT_STALL: begin
        pc_we_o     = 1'b0;
        ifid_we_o   = 1'b0;
        ctrl_zero_o = 1'b1;
      end
      ACT_BRANCH: flush.if_f = 1'b1;
      ACT_TRAP: begin
        flush       = '1;
        ctrl_zero_o = 1'b1;
        wb_kill_o   = 1'b1;
        redirect_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign flush_if_o    = flush.if_f;
  assign flush_id_o    = flush.id_f;
  assign flush_ex_o    = flush.ex_f;
  assign redirect_pc_o = redirect_o ? HANDLER_PC : '0;

  p_hold_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_o |-> !ifid_we_o && ctrl_zero_o && !flush_if_o);
  p_single_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_o |=> pc_we_o);
  p_branch_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_i && !ovf_i) |-> flush_if_o && !flush_id_o && !flush_ex_o && pc_we_o);
  p_trap_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> flush_if_o && flush_id_o && flush_ex_o && wb_kill_o
              && redirect_o && (redirect_pc_o == HANDLER_PC));
  p_trap_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> pc_we_o && ifid_we_o);
  p_no_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i |-> !wb_kill_o && !redirect_o);
endmodule

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
  localparam int REG_W = 5;
  localparam int ADDR_W = 32;
  localparam int CAUSE_W = 5;
  localparam logic [ADDR_W-1:0] HANDLER = 32'h180;
  localparam logic [CAUSE_W-1:0] CAUSE = 5'd12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0, br = 1'b0, ovf = 1'b0;
  logic [REG_W-1:0] dst = '0, sa = '0, sb = '0;
  logic [ADDR_W-1:0] pc = '0;
  logic pc_we, ifid_we, czero, f_if, f_id, f_ex, kill, redir;
  logic [ADDR_W-1:0] redir_pc, epc;
  logic [CAUSE_W-1:0] cause;

  int errors = 0;
  int checks = 0;
  logic m_prev = 1'b0;
  logic [ADDR_W-1:0] m_epc = '0;
  logic [CAUSE_W-1:0] m_cause = '0;

  always #4 clk = ~clk;

  hazard_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W),
                .HANDLER_PC(HANDLER), .CAUSE_OVF(CAUSE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ex_mem_rd_i(ld), .ex_dst_i(dst),
    .id_src_a_i(sa), .id_src_b_i(sb), .br_taken_i(br), .ovf_i(ovf),
    .ex_pc_i(pc), .pc_we_o(pc_we), .ifid_we_o(ifid_we), .ctrl_zero_o(czero),
    .flush_if_o(f_if), .flush_id_o(f_id), .flush_ex_o(f_ex), .wb_kill_o(kill),
    .redirect_o(redir), .redirect_pc_o(redir_pc), .epc_o(epc), .cause_o(cause)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, compare before rising edge
  task automatic step(input logic l, input logic [REG_W-1:0] d,
                      input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                      input logic bt, input logic ov, input logic [ADDR_W-1:0] p,
                      input string tag);
    logic hit;
    logic [2:0] e_hold;
    logic [2:0] e_fl;
    logic [1:0] e_kr;
    @(negedge clk);
    ld = l; dst = d; sa = a; sb = b; br = bt; ovf = ov; pc = p;
    #2;
    hit = l && (d == a || d == b);
    if (ov) begin
      e_hold = 3'b111; e_fl = 3'b111; e_kr = 2'b11;
    end else if (bt) begin
      e_hold = 3'b110; e_fl = 3'b100; e_kr = 2'b00;
    end else if (hit && !m_prev) begin
      e_hold = 3'b001; e_fl = 3'b000; e_kr = 2'b00;
    end else begin
      e_hold = 3'b110; e_fl = 3'b000; e_kr = 2'b00;
    end
    check({pc_we, ifid_we, czero} == e_hold, tag, "pc_we/ifid_we/zero",
          {pc_we, ifid_we, czero}, e_hold);
    check({f_if, f_id, f_ex} == e_fl, tag, "flush", {f_if, f_id, f_ex}, e_fl);
    check({kill, redir} == e_kr, tag, "kill/redirect", {kill, redir}, e_kr);
    check(redir_pc == (ov ? HANDLER : '0), tag, "redirect_pc", redir_pc,
          ov ? HANDLER : '0);
    check(epc == m_epc, tag, "epc", epc, m_epc);
    check(cause == m_cause, tag, "cause", cause, m_cause);
    m_prev = !ov && !bt && hit && !m_prev;
    if (ov) begin
      m_epc = p; m_cause = CAUSE;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    m_prev = 1'b0; m_epc = '0; m_cause = '0;
    repeat (2) @(negedge clk);
    check(epc == '0 && cause == '0, "R8", "reset epc/cause", {epc, cause}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, '0, "R8");
    step(1'b1, 5'd9, 5'd9, 5'd3, 1'b0, 1'b0, '0, "R8"); // first match stalls
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, '0, "R8");
  endtask

  task automatic t_quiet();
    step(1'b0, 5'd7, 5'd7, 5'd7, 1'b0, 1'b0, '0, "R2"); // match, no load
    step(1'b1, 5'd7, 5'd6, 5'd8, 1'b0, 1'b0, '0, "R2"); // load, no match
    step(1'b1, 5'd31, 5'd30, 5'd0, 1'b0, 1'b0, '0, "R2");
    step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, '0, "R9");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 5'(i), 5'(i), 5'(i ^ 1), 1'b0, 1'b0, '0, "R1");
      step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, '0, "R2");
      step(1'b1, 5'(i), 5'(i ^ 2), 5'(i), 1'b0, 1'b0, '0, "R1");
      step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, '0, "R2");
    end
  endtask

  task automatic t_single();
    step(1'b1, 5'd4, 5'd4, 5'd4, 1'b0, 1'b0, '0, "R3"); // stall
    step(1'b1, 5'd4, 5'd4, 5'd4, 1'b0, 1'b0, '0, "R3"); // runs
    step(1'b1, 5'd4, 5'd4, 5'd4, 1'b0, 1'b0, '0, "R3"); // may stall again
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, '0, "R3");
  endtask

  task automatic t_branch();
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b1, 1'b0, '0, "R4");
    step(1'b1, 5'd5, 5'd5, 5'd1, 1'b1, 1'b0, '0, "R4"); // stall dropped
    step(1'b1, 5'd5, 5'd5, 5'd1, 1'b0, 1'b0, '0, "R4"); // now it stalls
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, '0, "R9");
  endtask

  task automatic t_overflow();
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b1, 32'h0000_004C, "R5");
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, 32'h1111_1111, "R7");
    step(1'b1, 5'd3, 5'd3, 5'd3, 1'b1, 1'b1, 32'hDEAD_BEE0, "R6");
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b1, 1'b0, 32'h2222_2222, "R7");
    step(1'b1, 5'd6, 5'd1, 5'd6, 1'b0, 1'b0, 32'h3333_3333, "R7");
    step(1'b1, 5'd6, 5'd1, 5'd6, 1'b0, 1'b1, 32'h0000_0F00, "R6"); // after stall
    step(1'b0, 5'd0, 5'd1, 5'd2, 1'b0, 1'b0, '0, "R7");
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_quiet();
    t_sweep();
    t_single();
    t_branch();
    t_overflow();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule